// File: doc/BRIEF.md
# Interrupt Flag and Enable Controller

This block keeps the interrupt state of a parallel peripheral interface. It has seven interrupt sources: two timers, a shift register and four handshake control lines. Each source raises its own flag bit. The block then merges the flags that are both pending and enabled into one active-high interrupt request. Each source reports an event with a one-cycle set pulse and can drop its flag with a one-cycle clear pulse. Port data accesses clear the handshake flags that belong to that port.

The CPU side uses two registers, chosen by a one-bit select. The flag register reads back the seven flags and a live summary bit in the top position. Writing ones to it clears the flags at those positions. The enable register is changed in set-or-clear style, with the top bit of the written value choosing the direction. Register access is a plain single-cycle strobe with combinational read data. It has no valid/ready handshake and no back-pressure, because the peripheral completes every access in the cycle it is presented.

Top module: `irq_flag_ctrl`

## Requirements
- R1: Flag bit positions are fixed: timer one = 6, timer two = 5, port B line one = 4, port B line two = 3, shift register = 2, port A line one = 1, port A line two = 0. A set pulse on `src_set[i]` sets flag i on the next clock edge.
- R2: With `reg_addr` = 0, `reg_rdata[6:0]` returns the flags and `reg_rdata[7]` is 1 exactly when some bit is set in both the flags and the enables.
- R3: `irq` is registered. It equals the summary of the flag and enable state of the previous cycle, so it changes one cycle after the state changes.
- R4: A write with `reg_addr` = 0 clears each flag whose written bit in 6:0 is 1. Bit 7 of the written value is ignored.
- R5: A write with `reg_addr` = 1 and `reg_wdata[7]` = 1 sets each enable bit written as 1 and leaves the other enable bits unchanged.
- R6: A write with `reg_addr` = 1 and `reg_wdata[7]` = 0 clears each enable bit written as 1 and leaves the other enable bits unchanged.
- R7: With `reg_addr` = 1, `reg_rdata[6:0]` returns the enables and `reg_rdata[7]` always reads 1.
- R8: A `flag_rst` pulse clears all flags and leaves the enables unchanged.
- R9: `rst_n` low clears the flags, the enables and `irq`.
- R10: A `pb_access` pulse clears flag 4. It also clears flag 3 unless `cb2_indep` is 1.
- R11: A `pa_access` pulse clears flag 1. It also clears flag 0 unless `ca2_indep` is 1.
- R12: When a set pulse and any clear cause hit the same flag in the same cycle, the flag ends up set.
- R13: A pulse on `src_clr[i]` clears flag i.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous full reset, active low |
| flag_rst | input | 1 | Synchronous reset of the flags only |
| src_set | input | 7 | Per-source set pulses |
| src_clr | input | 7 | Per-source clear pulses |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 1 | Register select: 0 flags, 1 enables |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data, combinational on `reg_addr` |
| pa_access | input | 1 | Port A data read or write happened |
| pb_access | input | 1 | Port B data read or write happened |
| ca2_indep | input | 1 | Port A line two is in independent mode |
| cb2_indep | input | 1 | Port B line two is in independent mode |
| irq | output | 1 | Registered interrupt request, active high |

## Verification
The bench builds the block with its default of seven sources. This is the only width at which the fixed flag positions of the handshake lines, and the summary bit directly above them, exist. A vector table takes the flags and enables through set and clear writes and both port-access clears, with each independent-mode setting. It also covers collisions of set pulses against a flag write, a source clear and a port clear. After each step it reads both registers and checks the one-cycle lag of `irq`. Directed tests then cover the full reset and the flags-only reset.

// File: rtl/irqc_pkg.sv
package irqc_pkg;
  localparam int SRC_W   = 7;
  // flag positions decoded by neighbouring blocks
  localparam int POS_T1  = 6;
  localparam int POS_T2  = 5;
  localparam int POS_PB1 = 4;
  localparam int POS_PB2 = 3;
  localparam int POS_SR  = 2;
  localparam int POS_PA1 = 1;
  localparam int POS_PA2 = 0;
  localparam logic SEL_FLAG = 1'b0;
  localparam logic SEL_ENA  = 1'b1;
endpackage

// File: rtl/irqc_clear_gen.sv
module irqc_clear_gen #(
  parameter int NSRC = irqc_pkg::SRC_W
) (
  input  logic [NSRC-1:0] src_clr,
  input  logic            flag_wr,
  input  logic [NSRC-1:0] wr_bits,
  input  logic            pa_access,
  input  logic            pb_access,
  input  logic            ca2_indep,
  input  logic            cb2_indep,
  output logic [NSRC-1:0] clr_vec
);
  import irqc_pkg::*;

  always_comb begin
    clr_vec = src_clr;
    if (flag_wr) clr_vec = clr_vec | wr_bits;
    if (pb_access) begin
      clr_vec[POS_PB1] = 1'b1;
      if (!cb2_indep) clr_vec[POS_PB2] = 1'b1;
    end
    if (pa_access) begin
      clr_vec[POS_PA1] = 1'b1;
      if (!ca2_indep) clr_vec[POS_PA2] = 1'b1;
    end
  end
endmodule

// File: rtl/irqc_flag_bank.sv
module irqc_flag_bank #(
  parameter int NSRC = irqc_pkg::SRC_W
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            flag_rst,
  input  logic [NSRC-1:0] set_vec,
  input  logic [NSRC-1:0] clr_vec,
  output logic [NSRC-1:0] flag_q
);
  for (genvar i = 0; i < NSRC; i++) begin : g_flag
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          flag_q[i] <= 1'b0;
      else if (flag_rst)   flag_q[i] <= 1'b0;
      else if (set_vec[i]) flag_q[i] <= 1'b1;  // set beats clear
      else if (clr_vec[i]) flag_q[i] <= 1'b0;
    end
  end
endmodule

// File: rtl/irqc_enable_reg.sv
module irqc_enable_reg #(
  parameter int NSRC = irqc_pkg::SRC_W
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            ena_wr,
  input  logic            set_mode,
  input  logic [NSRC-1:0] wr_bits,
  output logic [NSRC-1:0] en_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       en_q <= '0;
    else if (ena_wr) begin
      if (set_mode)   en_q <= en_q | wr_bits;
      else            en_q <= en_q & ~wr_bits;
    end
  end
endmodule

// File: rtl/irq_flag_ctrl.sv
module irq_flag_ctrl #(
  parameter int NSRC = irqc_pkg::SRC_W,
  localparam int DW  = NSRC + 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            flag_rst,
  input  logic [NSRC-1:0] src_set,
  input  logic [NSRC-1:0] src_clr,
  input  logic            reg_wr,
  input  logic            reg_addr,
  input  logic [DW-1:0]   reg_wdata,
  output logic [DW-1:0]   reg_rdata,
  input  logic            pa_access,
  input  logic            pb_access,
  input  logic            ca2_indep,
  input  logic            cb2_indep,
  output logic            irq
);
  import irqc_pkg::*;

  logic [NSRC-1:0] clr_vec;
  logic [NSRC-1:0] flag_q;
  logic [NSRC-1:0] en_q;
  logic            flag_wr;
  logic            ena_wr;
  logic            pending;

  assign flag_wr = reg_wr && (reg_addr == SEL_FLAG);
  assign ena_wr  = reg_wr && (reg_addr == SEL_ENA);

  irqc_clear_gen #(.NSRC(NSRC)) u_clr (
    .src_clr   (src_clr),
    .flag_wr   (flag_wr),
    .wr_bits   (reg_wdata[NSRC-1:0]),
    .pa_access (pa_access),
    .pb_access (pb_access),
    .ca2_indep (ca2_indep),
    .cb2_indep (cb2_indep),
    .clr_vec   (clr_vec)
  );

  irqc_flag_bank #(.NSRC(NSRC)) u_flags (
    .clk      (clk),
    .rst_n    (rst_n),
    .flag_rst (flag_rst),
    .set_vec  (src_set),
    .clr_vec  (clr_vec),
    .flag_q   (flag_q)
  );

  irqc_enable_reg #(.NSRC(NSRC)) u_ena (
    .clk      (clk),
    .rst_n    (rst_n),
    .ena_wr   (ena_wr),
    .set_mode (reg_wdata[NSRC]),
    .wr_bits  (reg_wdata[NSRC-1:0]),
    .en_q     (en_q)
  );

  assign pending = |(flag_q & en_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) irq <= 1'b0;
    else        irq <= pending;
  end

  always_comb begin
    if (reg_addr == SEL_FLAG) reg_rdata = {pending, flag_q};
    else                      reg_rdata = {1'b1, en_q};
  end
endmodule

// File: rtl/irq_flag_ctrl_chk.sv
module irq_flag_ctrl_chk #(
  parameter int NSRC = irqc_pkg::SRC_W
) (
  input logic            clk,
  input logic            rst_n,
  input logic            flag_rst,
  input logic [NSRC-1:0] src_set,
  input logic            reg_wr,
  input logic            reg_addr,
  input logic [NSRC:0]   reg_wdata,
  input logic [NSRC-1:0] flag_q,
  input logic [NSRC-1:0] en_q,
  input logic            irq
);
  import irqc_pkg::*;

  p_set_wins_r12: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ($past(flag_rst) || ((flag_q & $past(src_set)) == $past(src_set))));

  p_flag_wr_clears_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_addr == SEL_FLAG) |=>
      ((flag_q & $past(reg_wdata[NSRC-1:0] & ~src_set)) == '0));

  p_en_set_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_addr == SEL_ENA && reg_wdata[NSRC]) |=>
      ((en_q & $past(reg_wdata[NSRC-1:0])) == $past(reg_wdata[NSRC-1:0])));

  p_en_clr_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_addr == SEL_ENA && !reg_wdata[NSRC]) |=>
      ((en_q & $past(reg_wdata[NSRC-1:0])) == '0));

  p_irq_lag_r3: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (irq == $past(|(flag_q & en_q))));

  p_flag_rst_r8: assert property (@(posedge clk) disable iff (!rst_n)
    flag_rst |=> (flag_q == '0));

  p_en_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !reg_wr |=> $stable(en_q));
endmodule

bind irq_flag_ctrl irq_flag_ctrl_chk #(.NSRC(NSRC)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .flag_rst  (flag_rst),
  .src_set   (src_set),
  .reg_wr    (reg_wr),
  .reg_addr  (reg_addr),
  .reg_wdata (reg_wdata),
  .flag_q    (flag_q),
  .en_q      (en_q),
  .irq       (irq)
);

// File: tb/irq_flag_ctrl_tb.sv
module irq_flag_ctrl_tb;
  localparam int CLK_PERIOD = 10;
  localparam int NSRC = 7;
  localparam int NV = 19;

  typedef struct packed {
    logic [23:0] tag;
    logic [6:0]  set;
    logic [6:0]  clr;
    logic        wr;
    logic        addr;
    logic [7:0]  wdata;
    logic        pb;
    logic        pa;
    logic        indep;
    logic [7:0]  eflag;
    logic [7:0]  een;
  } vec_t;

  // flags/enables start from zero after reset
  localparam vec_t VECS [NV] = '{
    '{"R5 ", 7'h00, 7'h00, 1'b1, 1'b1, 8'hE0, 1'b0, 1'b0, 1'b0, 8'h00, 8'hE0},
    '{"R1 ", 7'h40, 7'h00, 1'b0, 1'b0, 8'h00, 1'b0, 1'b0, 1'b0, 8'hC0, 8'hE0},
    '{"R4 ", 7'h00, 7'h00, 1'b1, 1'b0, 8'hBF, 1'b0, 1'b0, 1'b0, 8'hC0, 8'hE0},
    '{"R4 ", 7'h00, 7'h00, 1'b1, 1'b0, 8'h40, 1'b0, 1'b0, 1'b0, 8'h00, 8'hE0},
    '{"R2 ", 7'h1F, 7'h00, 1'b0, 1'b0, 8'h00, 1'b0, 1'b0, 1'b0, 8'h1F, 8'hE0},
    '{"R10", 7'h00, 7'h00, 1'b0, 1'b0, 8'h00, 1'b1, 1'b0, 1'b0, 8'h07, 8'hE0},
    '{"R11", 7'h00, 7'h00, 1'b0, 1'b0, 8'h00, 1'b0, 1'b1, 1'b1, 8'h05, 8'hE0},
    '{"R11", 7'h00, 7'h00, 1'b0, 1'b0, 8'h00, 1'b0, 1'b1, 1'b0, 8'h04, 8'hE0},
    '{"R1 ", 7'h18, 7'h00, 1'b0, 1'b0, 8'h00, 1'b0, 1'b0, 1'b0, 8'h1C, 8'hE0},
    '{"R10", 7'h00, 7'h00, 1'b0, 1'b0, 8'h00, 1'b1, 1'b0, 1'b1, 8'h0C, 8'hE0},
    '{"R6 ", 7'h00, 7'h00, 1'b1, 1'b1, 8'h20, 1'b0, 1'b0, 1'b0, 8'h0C, 8'hC0},
    '{"R5 ", 7'h00, 7'h00, 1'b1, 1'b1, 8'h84, 1'b0, 1'b0, 1'b0, 8'h8C, 8'hC4},
    '{"R13", 7'h00, 7'h04, 1'b0, 1'b0, 8'h00, 1'b0, 1'b0, 1'b0, 8'h08, 8'hC4},
    '{"R12", 7'h20, 7'h20, 1'b0, 1'b0, 8'h00, 1'b0, 1'b0, 1'b0, 8'h28, 8'hC4},
    '{"R12", 7'h08, 7'h00, 1'b1, 1'b0, 8'h08, 1'b0, 1'b0, 1'b0, 8'h28, 8'hC4},
    '{"R12", 7'h01, 7'h00, 1'b0, 1'b0, 8'h00, 1'b0, 1'b1, 1'b0, 8'h29, 8'hC4},
    '{"R5 ", 7'h00, 7'h00, 1'b1, 1'b1, 8'hFF, 1'b0, 1'b0, 1'b0, 8'hA9, 8'hFF},
    '{"R4 ", 7'h00, 7'h00, 1'b1, 1'b0, 8'hFF, 1'b0, 1'b0, 1'b0, 8'h00, 8'hFF},
    '{"R7 ", 7'h00, 7'h00, 1'b1, 1'b1, 8'h7F, 1'b0, 1'b0, 1'b0, 8'h00, 8'h80}
  };

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic            flag_rst = 1'b0;
  logic [NSRC-1:0] src_set = '0;
  logic [NSRC-1:0] src_clr = '0;
  logic            reg_wr = 1'b0;
  logic            reg_addr = 1'b0;
  logic [NSRC:0]   reg_wdata = '0;
  logic [NSRC:0]   reg_rdata;
  logic            pa_access = 1'b0;
  logic            pb_access = 1'b0;
  logic            ca2_indep = 1'b0;
  logic            cb2_indep = 1'b0;
  logic            irq;

  int n_chk = 0;
  int n_bad = 0;
  logic prev_sum = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  irq_flag_ctrl #(.NSRC(NSRC)) u_dut (
    .clk(clk), .rst_n(rst_n), .flag_rst(flag_rst),
    .src_set(src_set), .src_clr(src_clr),
    .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .pa_access(pa_access), .pb_access(pb_access),
    .ca2_indep(ca2_indep), .cb2_indep(cb2_indep), .irq(irq)
  );

  task automatic check(input string req, input string what,
                       input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %02h expected %02h", req, what, act, exp);
    end
  endtask

  task automatic drive_idle();
    src_set = '0; src_clr = '0; reg_wr = 1'b0; reg_wdata = '0;
    pa_access = 1'b0; pb_access = 1'b0; flag_rst = 1'b0;
  endtask

  task automatic read_both(input string req, input logic [7:0] ef, input logic [7:0] ee);
    reg_addr = 1'b0; #1;
    check(req, "flag read", reg_rdata, ef);
    reg_addr = 1'b1; #1;
    check(req, "enable read", reg_rdata, ee);
  endtask

  initial begin
    repeat (3000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual hung expected done");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R9: reset state
    read_both("R9", 8'h00, 8'h80);
    check("R9", "irq after reset", {7'd0, irq}, 8'h00);

    for (int v = 0; v < NV; v++) begin
      @(negedge clk);
      src_set = VECS[v].set; src_clr = VECS[v].clr;
      reg_wr = VECS[v].wr; reg_addr = VECS[v].addr; reg_wdata = VECS[v].wdata;
      pb_access = VECS[v].pb; pa_access = VECS[v].pa;
      ca2_indep = VECS[v].indep; cb2_indep = VECS[v].indep;
      @(negedge clk);
      drive_idle();
      read_both(string'(VECS[v].tag), VECS[v].eflag, VECS[v].een);
      // R3: irq still shows the previous state one cycle after the change
      check("R3", "irq lag", {7'd0, irq}, {7'd0, prev_sum});
      @(negedge clk);
      check("R3", "irq follow", {7'd0, irq}, {7'd0, VECS[v].eflag[7]});
      prev_sum = VECS[v].eflag[7];
    end

    // R8: flag-only reset keeps enables
    reg_wr = 1'b1; reg_addr = 1'b1; reg_wdata = 8'hFF;
    src_set = 7'h7F;
    @(negedge clk);
    drive_idle();
    @(negedge clk);
    read_both("R8", 8'hFF, 8'hFF);
    check("R8", "irq before flag reset", {7'd0, irq}, 8'h01);
    flag_rst = 1'b1;
    src_set = 7'h10;
    @(negedge clk);
    drive_idle();
    read_both("R8", 8'h00, 8'hFF);
    @(negedge clk);
    check("R8", "irq after flag reset", {7'd0, irq}, 8'h00);

    // R9: full reset clears enables and irq
    src_set = 7'h02;
    @(negedge clk);
    drive_idle();
    @(negedge clk);
    check("R9", "irq pending", {7'd0, irq}, 8'h01);
    rst_n = 1'b0; #1;
    read_both("R9", 8'h00, 8'h80);
    check("R9", "irq in reset", {7'd0, irq}, 8'h00);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    read_both("R9", 8'h00, 8'h80);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule